// File: doc/BRIEF.md
# Dual Watchpoint Comparator Unit

This block is a debug trigger that watches a processor's bus and raises a halt request. It holds two programmable comparator units. Each unit checks the live address, the data and a small control field (read/write, fetch/data, access size) against programmed values. A per-bit mask removes any bit from the comparison. Each unit is set to qualify either on instruction fetches, which makes it a breakpoint, or on data accesses, which makes it a watchpoint. Each unit has its own enable.

A global control word lets the two units work together. In chain mode a hit on unit 0 arms a latch, and only a later hit on unit 1 raises halt. In range mode a hit on unit 0 that is not also a hit on unit 1 raises halt. This expresses an include-minus-exclude window, such as the bottom 256 bytes without the bottom 32. A status word records which unit caused the last halt, together with a sticky pending flag.

Software programs the block through a simple parallel register port with combinational readback. Bus cycles count only while `bus_valid` is high. Halt is a registered one-cycle pulse.

Top module: `dbg_trigger_unit`

## Requirements
- R1: A unit hits only when every unmasked bit of address, data and control (bit0 write, bit1 fetch, bits 3:2 size) equals its programmed value; a mask bit of 1 ignores that bit, 0 compares it.
- R2: Enable word bit1 = 1 makes a unit a breakpoint that hits only on fetch cycles (control bit1 = 1); bit1 = 0 makes it a watchpoint that hits only on data cycles (control bit1 = 0).
- R3: With both mode bits clear, halt follows any unit whose enable word bit0 is 1 and that hits; a cycle with `bus_valid` low never causes halt.
- R4: `halt` is registered: it is high for exactly the one clock after the qualifying bus cycle.
- R5: Chain mode (global bit0 = 1): an enabled unit-0 hit arms a latch without halting; a unit-1 hit in a later cycle while armed raises halt; a unit-1 hit with the latch clear does not.
- R6: The chain latch clears when halt is raised, while chain mode is 0 (including after writing it to 0), and on reset.
- R7: Range mode (global bit1 = 1, bit0 = 0): halt when unit 0 is enabled and hits and unit 1 does not hit; unit 1's enable bit has no effect in this mode.
- R8: Status (address 17) bits 1:0 show the units credited with the last halt (bit0 unit 0, bit1 unit 1; chain credits unit 1, range credits unit 0); bit2 is a sticky pending flag set by halt and cleared by writing 1 to bit2.
- R9: Register map: unit u field k at address 8u+k with k = 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask, 6 enable word; global control at 16; every register reads back what was written and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the register at reg_addr |
| bus_valid | input | 1 | Qualifies the bus cycle |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| bus_write | input | 1 | 1 = write cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_size | input | 2 | Access size code |
| halt | output | 1 | Registered halt request pulse |

## Verification
The bench first moves a single address bit across the mask boundary. A design that inverted the mask sense or dropped a field from the compare would halt on the wrong address. It then presents data cycles to a breakpoint and fetches to a watchpoint, which catches a design that ignores the unit kind.

For chain mode, the bench sends unit 1 before unit 0 and both units in the same cycle. It repeats unit 1 after a halt and again after chain mode was toggled off and back on. A design that does not remember order, or never clears the latch, would halt early or twice.

Range mode is probed at 0x1F, 0x20, 0x80 and 0x100 with unit 1 disabled. This exposes an off-by-one window, and it exposes a design that lets unit 1's enable gate the exclusion.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int CTRL_W    = 4;
    localparam int NUM_UNITS = 2;
    localparam int REG_AW    = 5;

    localparam logic [REG_AW-1:0] GLOBAL_ADDR = REG_AW'(16);
    localparam logic [REG_AW-1:0] STATUS_ADDR = REG_AW'(17);

    // control field: bit0 write, bit1 fetch, bits 3:2 size
    typedef struct packed {
        logic [1:0] size;
        logic       fetch;
        logic       write;
    } bus_ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr_val;
        logic [ADDR_W-1:0] addr_msk;
        logic [DATA_W-1:0] data_val;
        logic [DATA_W-1:0] data_msk;
        logic [CTRL_W-1:0] ctrl_val;
        logic [CTRL_W-1:0] ctrl_msk;
        logic              enable;
        logic              is_break;
    } unit_cfg_t;

    typedef enum logic [2:0] {
        FLD_ADDR_VAL = 3'd0,
        FLD_ADDR_MSK = 3'd1,
        FLD_DATA_VAL = 3'd2,
        FLD_DATA_MSK = 3'd3,
        FLD_CTRL_VAL = 3'd4,
        FLD_CTRL_MSK = 3'd5,
        FLD_ENABLE   = 3'd6
    } unit_field_e;
endpackage

// File: rtl/trig_match.sv
module trig_match
    import dbg_trig_pkg::*;
(
    input  unit_cfg_t         cfg,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  bus_ctrl_t         bus_ctrl,
    output logic              hit
);
    logic addr_ok;
    logic data_ok;
    logic ctrl_ok;
    logic kind_ok;

    always_comb begin
        addr_ok = ~|((bus_addr ^ cfg.addr_val) & ~cfg.addr_msk);
        data_ok = ~|((bus_data ^ cfg.data_val) & ~cfg.data_msk);
        ctrl_ok = ~|((CTRL_W'(bus_ctrl) ^ cfg.ctrl_val) & ~cfg.ctrl_msk);
        kind_ok = cfg.is_break ? bus_ctrl.fetch : ~bus_ctrl.fetch;
        hit     = bus_valid & addr_ok & data_ok & ctrl_ok & kind_ok;
    end
endmodule

// File: rtl/trig_regs.sv
module trig_regs
    import dbg_trig_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         fire,
    input  logic [NUM_UNITS-1:0]         fire_cause,
    output unit_cfg_t [NUM_UNITS-1:0]    cfg,
    output logic                         chain_mode,
    output logic                         range_mode,
    output logic [NUM_UNITS-1:0]         cause,
    output logic                         pending,
    output logic [DATA_W-1:0]            rdata
);
    typedef struct packed {
        unit_cfg_t [NUM_UNITS-1:0] unit;
        logic                      chain_en;
        logic                      range_en;
        logic [NUM_UNITS-1:0]      cause;
        logic                      pending;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel;
    unit_field_e fld;

    always_comb begin
        sel = addr[3];
        fld = unit_field_e'(addr[2:0]);
        r_d = r_q;
        if (wr_en) begin
            if (!addr[4]) begin
                case (fld)
                    FLD_ADDR_VAL: r_d.unit[sel].addr_val = wdata[ADDR_W-1:0];
                    FLD_ADDR_MSK: r_d.unit[sel].addr_msk = wdata[ADDR_W-1:0];
                    FLD_DATA_VAL: r_d.unit[sel].data_val = wdata;
                    FLD_DATA_MSK: r_d.unit[sel].data_msk = wdata;
                    FLD_CTRL_VAL: r_d.unit[sel].ctrl_val = wdata[CTRL_W-1:0];
                    FLD_CTRL_MSK: r_d.unit[sel].ctrl_msk = wdata[CTRL_W-1:0];
                    FLD_ENABLE: begin
                        r_d.unit[sel].enable   = wdata[0];
                        r_d.unit[sel].is_break = wdata[1];
                    end
                    default: ;
                endcase
            end else if (addr == GLOBAL_ADDR) begin
                r_d.chain_en = wdata[0];
                r_d.range_en = wdata[1];
            end else if (addr == STATUS_ADDR) begin
                if (wdata[2]) r_d.pending = 1'b0;
            end
        end
        // a new halt wins over a same-cycle clear
        if (fire) begin
            r_d.cause   = fire_cause;
            r_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg        = r_q.unit;
        chain_mode = r_q.chain_en;
        range_mode = r_q.range_en;
        cause      = r_q.cause;
        pending    = r_q.pending;
        rdata      = '0;
        if (!addr[4]) begin
            case (fld)
                FLD_ADDR_VAL: rdata = DATA_W'(r_q.unit[sel].addr_val);
                FLD_ADDR_MSK: rdata = DATA_W'(r_q.unit[sel].addr_msk);
                FLD_DATA_VAL: rdata = r_q.unit[sel].data_val;
                FLD_DATA_MSK: rdata = r_q.unit[sel].data_msk;
                FLD_CTRL_VAL: rdata = DATA_W'(r_q.unit[sel].ctrl_val);
                FLD_CTRL_MSK: rdata = DATA_W'(r_q.unit[sel].ctrl_msk);
                FLD_ENABLE:   rdata = DATA_W'({r_q.unit[sel].is_break, r_q.unit[sel].enable});
                default:      rdata = '0;
            endcase
        end else if (addr == GLOBAL_ADDR) begin
            rdata = DATA_W'({r_q.range_en, r_q.chain_en});
        end else if (addr == STATUS_ADDR) begin
            rdata = DATA_W'({r_q.pending, r_q.cause});
        end
    end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import dbg_trig_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] hit,
    input  logic [NUM_UNITS-1:0] en,
    input  logic                 chain_mode,
    input  logic                 range_mode,
    output logic                 fire,
    output logic [NUM_UNITS-1:0] fire_cause,
    output logic                 halt,
    output logic                 armed
);
    typedef struct packed {
        logic armed;
        logic halt;
    } seq_t;

    seq_t s_d, s_q;
    logic [NUM_UNITS-1:0] qual;

    always_comb begin
        qual       = hit & en;
        fire       = 1'b0;
        fire_cause = '0;
        if (chain_mode) begin
            fire       = s_q.armed & qual[1];
            fire_cause = 2'b10;
        end else if (range_mode) begin
            fire       = qual[0] & ~hit[1];
            fire_cause = 2'b01;
        end else begin
            fire       = |qual;
            fire_cause = qual;
        end

        s_d.halt = fire;
        if (fire || !chain_mode) s_d.armed = 1'b0;
        else                     s_d.armed = s_q.armed | qual[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign halt  = s_q.halt;
    assign armed = s_q.armed;
endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import dbg_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_write,
    input  logic              bus_fetch,
    input  logic [1:0]        bus_size,
    output logic              halt
);
    unit_cfg_t [NUM_UNITS-1:0] cfg;
    logic [NUM_UNITS-1:0]      hit;
    logic [NUM_UNITS-1:0]      en;
    logic [NUM_UNITS-1:0]      fire_cause;
    logic [NUM_UNITS-1:0]      halt_cause;
    logic                      fire;
    logic                      chain_mode;
    logic                      range_mode;
    logic                      chain_armed;
    logic                      halt_pending;
    bus_ctrl_t                 bus_ctrl;

    assign bus_ctrl = '{size: bus_size, fetch: bus_fetch, write: bus_write};

    trig_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .fire       (fire),
        .fire_cause (fire_cause),
        .cfg        (cfg),
        .chain_mode (chain_mode),
        .range_mode (range_mode),
        .cause      (halt_cause),
        .pending    (halt_pending),
        .rdata      (reg_rdata)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        trig_match u_match (
            .cfg       (cfg[u]),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .bus_ctrl  (bus_ctrl),
            .hit       (hit[u])
        );
        assign en[u] = cfg[u].enable;
    end

    trig_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .en         (en),
        .chain_mode (chain_mode),
        .range_mode (range_mode),
        .fire       (fire),
        .fire_cause (fire_cause),
        .halt       (halt),
        .armed      (chain_armed)
    );
endmodule

// File: rtl/dbg_trig_checker.sv
module dbg_trig_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       halt,
    input logic       halt_pending,
    input logic [1:0] halt_cause,
    input logic       chain_mode,
    input logic       chain_armed
);
    // R3 / R4: halt only follows a valid bus cycle
    assert_halt_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> $past(bus_valid));

    // R8: every halt leaves the pending flag set
    assert_halt_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> halt_pending);

    // R8: every halt credits at least one unit
    assert_halt_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (halt_cause != 2'b00));

    // R5: a chained halt needs the latch armed beforehand
    assert_chain_armed_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && $past(chain_mode)) |-> $past(chain_armed));

    // R6: the latch is cleared together with the halt
    assert_chain_clears_on_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !chain_armed);

    // R6: latch stays clear while chain mode is off
    assert_chain_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chain_mode) |-> !chain_armed);
endmodule

bind dbg_trigger_unit dbg_trig_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .halt         (halt),
    .halt_pending (halt_pending),
    .halt_cause   (halt_cause),
    .chain_mode   (chain_mode),
    .chain_armed  (chain_armed)
);

// File: tb/tb_dbg_trigger_unit.sv
module tb_dbg_trigger_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        bus_write = 1'b0;
    logic        bus_fetch = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        halt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_trigger_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_write(bus_write),
        .bus_fetch(bus_fetch), .bus_size(bus_size), .halt(halt)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // one bus cycle; h is halt in the following clock
    task automatic cyc(input logic v, input logic [31:0] a, input logic [31:0] dt,
                       input logic w, input logic f, output logic [31:0] h);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = dt; bus_write = w; bus_fetch = f; bus_size = 2'b10;
        @(negedge clk);
        h = {31'b0, halt};
        bus_valid = 1'b0;
    endtask

    task automatic prog(input int u, input logic [31:0] av, input logic [31:0] am,
                        input logic [31:0] dv, input logic [31:0] dm,
                        input logic [31:0] cv, input logic [31:0] cm, input logic [31:0] en);
        wr(5'(u*8+0), av); wr(5'(u*8+1), am); wr(5'(u*8+2), dv); wr(5'(u*8+3), dm);
        wr(5'(u*8+4), cv); wr(5'(u*8+5), cm); wr(5'(u*8+6), en);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check({31'b0, halt}, 0, "R4 halt low after reset");
        rd(5'd17, d); check(d, 0, "R9 status resets to 0");
        rd(5'd0, d);  check(d, 0, "R9 unit0 address resets to 0");
        rd(5'd16, d); check(d, 0, "R9 global resets to 0");
        wr(5'd9, 32'hA5A5_0F0F); rd(5'd9, d); check(d, 32'hA5A5_0F0F, "R9 unit1 address mask readback");
        wr(5'd14, 32'h3); rd(5'd14, d); check(d, 32'h3, "R9 unit1 enable readback");
        wr(5'd9, 0); wr(5'd14, 0);
    endtask

    task automatic t_break;
        logic [31:0] h, d;
        prog(0, 32'h1000, 0, 0, 32'hFFFF_FFFF, 32'h2, 32'hF, 32'h3);
        cyc(1, 32'h1000, 0, 0, 1, h); check(h, 1, "R3 breakpoint hit on fetch");
        @(negedge clk); check({31'b0, halt}, 0, "R4 halt lasts one cycle");
        rd(5'd17, d); check(d, 32'h5, "R8 status unit0 + pending");
        cyc(1, 32'h1004, 0, 0, 1, h); check(h, 0, "R1 address mismatch no halt");
        cyc(1, 32'h1000, 0, 0, 0, h); check(h, 0, "R2 breakpoint ignores data access");
        cyc(0, 32'h1000, 0, 0, 1, h); check(h, 0, "R3 invalid cycle ignored");
        wr(5'd17, 32'h4); rd(5'd17, d); check(d, 32'h1, "R8 write-1 clears pending");
        wr(5'd1, 32'hFF);
        cyc(1, 32'h10AB, 0, 0, 1, h); check(h, 1, "R1 masked address bits ignored");
        cyc(1, 32'h11AB, 0, 0, 1, h); check(h, 0, "R1 unmasked address bit compared");
        prog(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_watch;
        logic [31:0] h, d;
        prog(1, 32'h2000, 0, 32'hDEAD_BEEF, 0, 32'h1, 32'hE, 32'h1);
        cyc(1, 32'h2000, 32'hDEAD_BEEF, 1, 0, h); check(h, 1, "R2 watchpoint hit on data write");
        rd(5'd17, d); check(d, 32'h6, "R8 status unit1 + pending");
        cyc(1, 32'h2000, 32'hDEAD_BEEF, 0, 0, h); check(h, 0, "R1 control write bit compared");
        cyc(1, 32'h2000, 32'hDEAD_BEEE, 1, 0, h); check(h, 0, "R1 data bit compared");
        cyc(1, 32'h2000, 32'hDEAD_BEEF, 1, 1, h); check(h, 0, "R2 watchpoint ignores fetch");
        wr(5'd14, 32'h0);
        cyc(1, 32'h2000, 32'hDEAD_BEEF, 1, 0, h); check(h, 0, "R3 disabled unit no halt");
        prog(1, 0, 0, 0, 0, 0, 0, 0);
        wr(5'd17, 32'h4);
    endtask

    task automatic t_chain;
        logic [31:0] h, d;
        prog(0, 32'h100, 0, 0, 32'hFFFF_FFFF, 0, 32'hF, 32'h3);
        prog(1, 32'h200, 0, 0, 32'hFFFF_FFFF, 0, 32'hF, 32'h3);
        wr(5'd16, 32'h1);
        cyc(1, 32'h200, 0, 0, 1, h); check(h, 0, "R5 unit1 before arm no halt");
        cyc(1, 32'h100, 0, 0, 1, h); check(h, 0, "R5 unit0 arms without halt");
        cyc(1, 32'h300, 0, 0, 1, h); check(h, 0, "R5 unrelated cycle no halt");
        cyc(1, 32'h200, 0, 0, 1, h); check(h, 1, "R5 unit1 after arm halts");
        rd(5'd17, d); check(d, 32'h6, "R8 chain credits unit1");
        cyc(1, 32'h200, 0, 0, 1, h); check(h, 0, "R6 latch cleared by halt");
        cyc(1, 32'h100, 0, 0, 1, h);
        wr(5'd16, 32'h0); wr(5'd16, 32'h1);
        cyc(1, 32'h200, 0, 0, 1, h); check(h, 0, "R6 latch cleared by chain off");
        wr(5'd8, 32'h100);
        cyc(1, 32'h100, 0, 0, 1, h); check(h, 0, "R5 same-cycle hits only arm");
        cyc(1, 32'h100, 0, 0, 1, h); check(h, 1, "R5 later unit1 hit halts");
        wr(5'd16, 32'h0); wr(5'd17, 32'h4);
        prog(0, 0, 0, 0, 0, 0, 0, 0); prog(1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_range;
        logic [31:0] h, d;
        prog(0, 0, 32'hFF, 0, 32'hFFFF_FFFF, 0, 32'hF, 32'h1);
        prog(1, 0, 32'h1F, 0, 32'hFFFF_FFFF, 0, 32'hF, 32'h0);
        wr(5'd16, 32'h2);
        cyc(1, 32'h80, 0, 0, 0, h);  check(h, 1, "R7 inside window halts");
        rd(5'd17, d); check(d, 32'h5, "R8 range credits unit0");
        cyc(1, 32'h10, 0, 0, 0, h);  check(h, 0, "R7 excluded bottom no halt");
        cyc(1, 32'h1F, 0, 0, 0, h);  check(h, 0, "R7 top of exclusion no halt");
        cyc(1, 32'h20, 0, 0, 0, h);  check(h, 1, "R7 first address past exclusion");
        cyc(1, 32'h100, 0, 0, 0, h); check(h, 0, "R7 above window no halt");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_break();
        t_watch();
        t_chain();
        t_range();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule